// File: doc/BRIEF.md
# Hybrid Strict/Weighted Egress Scheduler

This block decides, for one transmit port, which of four priority queues sends its next packet. Each queue has its own configuration byte. That byte sets the queue either to strict priority or to weighted service. A weighted queue is allowed a programmed number of packets in each scheduling round. Strict and weighted queues can be mixed freely in one scheduler. The transmit MAC reports the end of each packet with a one-cycle strobe. The scheduler holds its grant until that strobe arrives and then picks again.

Credit is counted per queue and is spent only when a packet completes. A round closes once no non-empty weighted queue has credit left. At that point every queue's credit is refilled from its configured count. A mode input reduces the scheduler to two queues: queue 0 is then the low-priority queue and queue 1 the high-priority queue.

Top module: `hybrid_egress_sched`

## Requirements
- R1: While reset is low and after its release, `grant_vld` is 0. Reset sets every queue to weighted mode, with counts 1, 2, 4 and 8 for queues 0, 1, 2 and 3.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the configuration byte of queue `cfg_sel`, and the next arbitration uses the new byte. In that byte, bit 7 = 1 selects weighted mode, bit 7 = 0 selects strict mode, and bits 6:0 hold the packet count.
- R3: A non-empty strict queue is granted ahead of every lower-numbered queue. It keeps winning for as long as it is non-empty.
- R4: A weighted queue sends at most its count of packets per round. Among the weighted queues that still hold credit, the highest-numbered non-empty one wins, unless a higher strict queue is non-empty.
- R5: When some queue is non-empty and no non-empty weighted queue has credit left, every queue's credit is reloaded from its configured count before the choice is made.
- R6: A weighted queue configured with a count of 0 behaves exactly like a count of 1.
- R7: A grant and its queue index stay unchanged until `pkt_done`. Credit is decremented only on `pkt_done`, and only for a weighted queue. A `pkt_done` while no grant is valid has no effect.
- R8: When no grant is held, or in the cycle `pkt_done` arrives, the choice is made from that cycle's flags and appears on the outputs in the next cycle.
- R9: If no eligible queue is non-empty when a choice is made, `grant_vld` drops in the next cycle and the credits are kept as they are.
- R10: With `four_q_mode` low, only queues 0 and 1 can be granted, and the non-empty flags of queues 2 and 3 are ignored.
- R11: `grant_q` carries the binary index of the granted queue. Queue 3 has the highest priority and queue 0 the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| q_nonempty | input | 4 | One flag per queue, high when the queue holds a packet |
| pkt_done | input | 1 | One-cycle strobe from the transmit MAC at the end of the granted packet |
| four_q_mode | input | 1 | 1 = four queues in use, 0 = only queues 0 and 1 |
| cfg_we | input | 1 | Write strobe for a configuration byte |
| cfg_sel | input | 2 | Queue whose configuration byte is written |
| cfg_wdata | input | 8 | Configuration byte: bit 7 = weighted mode, bits 6:0 = count |
| grant_vld | output | 1 | A grant is being held |
| grant_q | output | 2 | Index of the granted queue |

## Verification
A wrong credit value does not show at once. It appears as a grant sequence that is one packet too long or too short for a queue, and it first becomes visible at the end of the round in which that queue should have stopped. A missed or extra reload shows up as a queue that is skipped, or served again, after the last weighted credit is spent. A fault in the grant register or in the priority pick shows on `grant_q` one cycle after the deciding `pkt_done`. For these reasons the reference model is compared on every cycle, across long sequences of mixed rounds, and not only at isolated points.

// File: rtl/hes_pkg.sv
package hes_pkg;
    localparam int CFG_W = 8;
    localparam int CNT_W = CFG_W - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic weighted;
        cnt_t count;
    } qcfg_t;

    // power-of-two defaults, saturating at the field width
    function automatic cnt_t reset_count(int q);
        if (q < CNT_W - 1) return cnt_t'(1 << q);
        return '1;
    endfunction
endpackage

// File: rtl/hes_cfg_regs.sv
module hes_cfg_regs
    import hes_pkg::*;
#(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [QW-1:0]       wr_sel,
    input  logic [CFG_W-1:0]    wr_data,
    output qcfg_t [NQ-1:0]      cfg_o
);
    qcfg_t [NQ-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int q = 0; q < NQ; q++) begin
            if (wr_en && wr_sel == QW'(q)) cfg_d[q] = qcfg_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                cfg_q[q] <= '{weighted: 1'b1, count: reset_count(q)};
            end
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/hes_qstat.sv
module hes_qstat
    import hes_pkg::*;
(
    input  qcfg_t cfg,
    input  cnt_t  credit,
    input  logic  ne,
    output cnt_t  eff,
    output logic  strict,
    output logic  live,
    output logic  wpend,
    output logic  sreq
);
    // a zero count still grants one packet per round
    assign eff    = (cfg.count == '0) ? cnt_t'(1) : cfg.count;
    assign strict = !cfg.weighted;
    assign wpend  = ne && cfg.weighted;
    assign live   = wpend && (credit != '0);
    assign sreq   = ne && !cfg.weighted;
endmodule

// File: rtl/hes_pick.sv
module hes_pick #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input  logic [NQ-1:0] req,
    output logic          found,
    output logic [QW-1:0] idx
);
    // highest index wins: later iterations override earlier ones
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int q = 0; q < NQ; q++) begin
            if (req[q]) begin
                found = 1'b1;
                idx   = QW'(q);
            end
        end
    end
endmodule

// File: rtl/hybrid_egress_sched.sv
module hybrid_egress_sched
    import hes_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int LOW_SET = 2,
    localparam int QW     = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    q_nonempty,
    input  logic             pkt_done,
    input  logic             four_q_mode,
    input  logic             cfg_we,
    input  logic [QW-1:0]    cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             grant_vld,
    output logic [QW-1:0]    grant_q
);
    typedef struct packed {
        logic                       vld;
        logic [QW-1:0]              gq;
        logic [NQ-1:0][CNT_W-1:0]   cr;
    } sched_t;

    sched_t st_d, st_q;

    qcfg_t [NQ-1:0]            cfg_q;
    logic  [NQ-1:0]            mode_mask, ne;
    logic  [NQ-1:0]            strict_v, live_v, wpend_v, sreq_v, req;
    logic  [NQ-1:0][CNT_W-1:0] eff_v, cr_dec;
    logic                      pick_found, free, reload;
    logic  [QW-1:0]            pick_idx;

    hes_cfg_regs #(.NQ(NQ), .QW(QW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg_q)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        if (q < LOW_SET) begin : g_low
            assign mode_mask[q] = 1'b1;
        end else begin : g_high
            assign mode_mask[q] = four_q_mode;
        end

        hes_qstat u_stat (
            .cfg    (cfg_q[q]),
            .credit (cr_dec[q]),
            .ne     (ne[q]),
            .eff    (eff_v[q]),
            .strict (strict_v[q]),
            .live   (live_v[q]),
            .wpend  (wpend_v[q]),
            .sreq   (sreq_v[q])
        );
    end

    assign ne = q_nonempty & mode_mask;

    // spend one credit of the granted weighted queue when its packet ends
    always_comb begin
        cr_dec = st_q.cr;
        if (st_q.vld && pkt_done && !strict_v[st_q.gq] && st_q.cr[st_q.gq] != '0) begin
            cr_dec[st_q.gq] = st_q.cr[st_q.gq] - 1'b1;
        end
    end

    assign free   = !st_q.vld || pkt_done;
    assign reload = (|ne) && !(|live_v);
    assign req    = sreq_v | (reload ? wpend_v : live_v);

    hes_pick #(.NQ(NQ), .QW(QW)) u_pick (
        .req   (req),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.cr = cr_dec;
        if (free) begin
            st_d.vld = pick_found;
            if (pick_found) st_d.gq = pick_idx;
            if (reload)     st_d.cr = eff_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.gq  <= '0;
            for (int q = 0; q < NQ; q++) st_q.cr[q] <= reset_count(q);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_vld = st_q.vld;
    assign grant_q   = st_q.gq;
endmodule

// File: rtl/hes_chk.sv
module hes_chk #(
    parameter int NQ      = 4,
    parameter int LOW_SET = 2,
    parameter int QW      = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NQ-1:0] q_nonempty,
    input logic          pkt_done,
    input logic          four_q_mode,
    input logic          grant_vld,
    input logic [QW-1:0] grant_q,
    input logic [NQ-1:0] strict_v
);
    logic [NQ-1:0] ne_m;
    logic          pick_now;

    for (genvar q = 0; q < NQ; q++) begin : g_m
        if (q < LOW_SET) begin : g_lo
            assign ne_m[q] = q_nonempty[q];
        end else begin : g_hi
            assign ne_m[q] = q_nonempty[q] && four_q_mode;
        end
    end

    assign pick_now = !grant_vld || pkt_done;

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld && !pkt_done |=> grant_vld && $stable(grant_q));

    // R8
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_now && (|ne_m) |=> grant_vld);

    // R9
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_now && !(|ne_m) |=> !grant_vld);

    // R10
    two_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_now && !four_q_mode |=> !grant_vld || int'(grant_q) < LOW_SET);

    // R3
    top_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_now && ne_m[NQ-1] && strict_v[NQ-1] |=> grant_vld && grant_q == QW'(NQ-1));
endmodule

bind hybrid_egress_sched hes_chk #(.NQ(NQ), .LOW_SET(LOW_SET), .QW(QW)) u_hes_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_nonempty  (q_nonempty),
    .pkt_done    (pkt_done),
    .four_q_mode (four_q_mode),
    .grant_vld   (grant_vld),
    .grant_q     (grant_q),
    .strict_v    (strict_v)
);

// File: tb/hybrid_egress_sched_bench.sv
module hybrid_egress_sched_bench;
    localparam int NQ = 4;
    localparam int QW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [NQ-1:0] q_nonempty;
    logic          pkt_done;
    logic          four_q_mode;
    logic          cfg_we;
    logic [QW-1:0] cfg_sel;
    logic [7:0]    cfg_wdata;
    logic          grant_vld;
    logic [QW-1:0] grant_q;

    hybrid_egress_sched u_hybrid_egress_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_nonempty  (q_nonempty),
        .pkt_done    (pkt_done),
        .four_q_mode (four_q_mode),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .grant_vld   (grant_vld),
        .grant_q     (grant_q)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string tag = "R1";
    int    dly = 1;
    bit    stray = 1'b0;
    logic [NQ-1:0] force_ne = '0;
    int    load [NQ];
    int    sent [NQ];
    bit    m_w  [NQ];
    int    m_c  [NQ];
    int    m_cr [NQ];
    bit    m_vld;
    int    m_gq;
    bit    mne  [NQ];
    bit    m_free, m_any, m_anyw, m_found;

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    function automatic int eff(int c);
        return (c == 0) ? 1 : c;
    endfunction

    // behavioural reference: credits per queue, spent on completion, refilled per round
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                m_w[q]  = 1'b1;
                m_c[q]  = 1 << q;
                m_cr[q] = 1 << q;
                sent[q] = 0;
            end
            m_vld = 1'b0;
            m_gq  = 0;
        end else begin
            for (int q = 0; q < NQ; q++) mne[q] = q_nonempty[q] && (four_q_mode || q < 2);
            m_free = !m_vld || pkt_done;
            if (m_vld && pkt_done) begin
                sent[m_gq]++;
                if (m_w[m_gq] && m_cr[m_gq] > 0) m_cr[m_gq]--;
            end
            if (m_free) begin
                m_any = 1'b0;
                m_anyw = 1'b0;
                for (int q = 0; q < NQ; q++) begin
                    if (mne[q]) m_any = 1'b1;
                    if (mne[q] && m_w[q] && m_cr[q] > 0) m_anyw = 1'b1;
                end
                if (m_any && !m_anyw)
                    for (int q = 0; q < NQ; q++) m_cr[q] = eff(m_c[q]);
                m_found = 1'b0;
                for (int q = NQ - 1; q >= 0; q--) begin
                    if (!m_found && mne[q] && (!m_w[q] || m_cr[q] > 0)) begin
                        m_found = 1'b1;
                        m_gq = q;
                    end
                end
                m_vld = m_found;
            end
            if (cfg_we) begin
                m_w[cfg_sel] = cfg_wdata[7];
                m_c[cfg_sel] = int'(cfg_wdata[6:0]);
            end
        end
    end

    // compare on every cycle, then drive flags and completion strobe
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", int'(grant_vld), 0);
        end else begin
            chk(tag, int'(grant_vld), int'(m_vld));
            if (m_vld) chk(tag, int'(grant_q), m_gq);
        end
        for (int q = 0; q < NQ; q++) q_nonempty[q] = (load[q] > sent[q]) || force_ne[q];
        pkt_done = (m_vld && (cyc % dly == 0)) || (stray && !m_vld && (cyc % 2 == 0));
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int q, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = QW'(q);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic add_all(int n);
        for (int q = 0; q < NQ; q++) load[q] += n;
    endtask

    int wd_fail = 0;

    initial begin
        rst_n = 1'b0;
        four_q_mode = 1'b1;
        cfg_we = 1'b0;
        cfg_sel = '0;
        cfg_wdata = '0;
        for (int q = 0; q < NQ; q++) load[q] = 0;
        fork
            begin
                run(4);
                rst_n = 1'b1;
                tag = "R1";
                run(4);
                add_all(12);
                run(80);
                tag = "R7";
                dly = 3;
                stray = 1'b1;
                add_all(10);
                run(160);
                stray = 1'b0;
                tag = "R8";
                dly = 1;
                load[2] += 3;
                run(20);
                tag = "R2";
                wr(1, 8'h05);
                tag = "R3";
                add_all(10);
                run(120);
                wr(3, 8'h02);
                add_all(6);
                run(80);
                tag = "R6";
                wr(2, 8'h80);
                wr(3, 8'h81);
                add_all(10);
                run(120);
                tag = "R9";
                run(40);
                load[0] += 3;
                run(20);
                tag = "R10";
                four_q_mode = 1'b0;
                force_ne = 4'b1100;
                load[0] += 6;
                load[1] += 6;
                run(60);
                force_ne = '0;
                four_q_mode = 1'b1;
                tag = "R11";
                wr(0, 8'h81);
                wr(1, 8'h82);
                wr(2, 8'h84);
                wr(3, 8'h88);
                load[3] += 2;
                load[0] += 5;
                run(40);
                for (int k = 0; k < 40; k++) begin
                    tag = (k % 2 == 0) ? "R4" : "R5";
                    for (int q = 0; q < NQ; q++) begin
                        wr(q, 8'($urandom_range(0, 255)));
                        load[q] += int'($urandom_range(0, 9));
                    end
                    dly = int'($urandom_range(1, 4));
                    stray = ($urandom_range(0, 3) == 0);
                    four_q_mode = ($urandom_range(0, 5) != 0);
                    run(100);
                end
                stray = 1'b0;
                run(10);
            end
            begin
                repeat (150000) @(posedge clk);
                wd_fail = 1;
                $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 150000);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + wd_fail, n_fail + wd_fail);
        $finish;
    end
endmodule